// File: doc/BRIEF.md
# Periodic Read Prefetch Cache Engine

This engine keeps a local copy of a small byte window that lives in one of two devices on a downstream serial bus. Software sets a start offset, a window length of 1 to 32 bytes, which of two device addresses to use, and a repeat interval counted in 5 ms ticks. When a start command is written, the engine fetches the window one byte at a time through an abstract request/done handshake. The handshake is served by a separate bus master. The engine then repeats the fetch at the programmed interval until a stop command is written. An interval of zero gives a single fetch.

Bytes arriving during a fetch go into a staging copy. The whole window is published to the served copy in one step, and only when every byte has been acknowledged. At that point a gate flag switches to serving. While the gate is serving, a host read whose address falls inside the published window hits and gets the cached byte at once. If any byte of a fetch is refused with a NACK, the fetch is abandoned and the gate closes by itself. The window settings are locked while the gate is serving: software releases the gate first, then reprograms the window. A write that breaks this rule is dropped and raises a sticky error flag.

Top module: `pfc_engine`

## Requirements
- R1: After reset the gate is not serving, the error flag is 0, no bus request is raised, and every host read misses with data 0.
- R2: Writing control register 6 with bit 0 set launches a fetch at once. The fetch issues one request per byte for offsets offset, offset+1 … offset+len-1, in increasing order. The window offset is register 1 and the length is register 2. The device is the one chosen by register 3 bit 0 (0 selects device 0, 1 selects device 1). Each request holds its offset and device until done.
- R3: With a nonzero interval in register 0, fetches repeat every interval × CLKS_PER_TICK clock cycles. With interval 0, a start gives exactly one fetch.
- R4: Writing register 6 with bit 1 set prevents any further launches. A fetch already under way runs to its end.
- R5: When a fetch finishes with every byte acknowledged, the gate becomes serving. A host read inside the window then hits and returns the most recently fetched byte for that address.
- R6: A host read misses, with data 0, when the address is outside the window, when the gate is not serving, or when the read strobe is low.
- R7: A NACK on any byte ends the fetch with no further requests, and the gate returns to not serving.
- R8: During a fetch, host reads keep returning the previous fetch's bytes until the last byte is acknowledged. All bytes of the window then change together.
- R9: While the gate is serving, writes to registers 1, 2 and 3 are ignored and set the sticky error flag. Writing register 6 with bit 2 set returns the gate to not serving, after which those writes take effect.
- R10: A length write of 0 or above 32 is ignored and sets the sticky error flag. The flag stays set until register 6 is written with bit 3 set.
- R11: Registers 4 and 5 hold the addresses of device 0 and device 1 in 8-bit form, with bit 0 dropped. They reset to 0xA0 and 0xA2, so the bus device output shows 0x50 and 0x51.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register index |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_err_o | output | 1 | Sticky error flag for rejected writes |
| gate_o | output | 1 | Gate flag, 1 when the window is being served |
| bus_req_o | output | 1 | Byte read request to the downstream master |
| bus_dev_o | output | 7 | 7-bit device address of the request |
| bus_off_o | output | 8 | Byte offset of the request |
| bus_done_i | input | 1 | One-cycle completion pulse of the current request |
| bus_nack_i | input | 1 | NACK qualifier, valid with bus_done_i |
| bus_rdata_i | input | 8 | Byte returned, valid with bus_done_i |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | 8 | Host read offset |
| host_hit_o | output | 1 | Host read served from the local copy |
| host_data_o | output | 8 | Cached byte on a hit, 0 otherwise |

## Verification
A wrong gate state appears at the host port in the cycle the read is presented: a hit with the gate closed, or a miss with the gate open. A broken staging path shows up as a read during a fetch that returns fresh bytes too early, or as a read that straddles two fetches with mixed bytes. Scheduling faults show on the request port within one interval, as extra fetches, missing fetches, or a wrong spacing between the first requests of consecutive fetches. A lost lock shows up at the next read as hits at a moved window while the gate is serving.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned DEV_W  = 7;

    typedef enum logic [2:0] {
        REG_PERIOD = 3'd0,
        REG_OFFSET = 3'd1,
        REG_LENGTH = 3'd2,
        REG_TSEL   = 3'd3,
        REG_DEV0   = 3'd4,
        REG_DEV1   = 3'd5,
        REG_CTRL   = 3'd6
    } cfg_reg_e;

    localparam int unsigned CTRL_START   = 0;
    localparam int unsigned CTRL_STOP    = 1;
    localparam int unsigned CTRL_RELEASE = 2;
    localparam int unsigned CTRL_ERRCLR  = 3;

    typedef enum logic [1:0] {
        F_IDLE  = 2'd0,
        F_ISSUE = 2'd1,
        F_GAP   = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/pfc_sched.sv
module pfc_sched #(
    parameter int unsigned CLKS_PER_TICK = 625000,
    parameter int unsigned PERIOD_W      = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                launch_o
);
    localparam int unsigned PRE_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;

    typedef struct packed {
        logic [PRE_W-1:0]    pre;
        logic [PERIOD_W-1:0] ticks;
        logic                active;
        logic                launch;
    } sched_t;

    sched_t s_q, s_d;
    logic   tick;

    always_comb begin
        s_d        = s_q;
        s_d.launch = 1'b0;
        tick       = (s_q.pre == PRE_W'(CLKS_PER_TICK - 1));
        s_d.pre    = tick ? '0 : s_q.pre + 1'b1;
        if (stop_i) begin
            s_d.active = 1'b0;
            s_d.ticks  = '0;
        end else if (start_i) begin
            s_d.active = (period_i != '0);
            s_d.ticks  = '0;
            s_d.launch = 1'b1;
        end else if (s_q.active && (period_i == '0)) begin
            s_d.active = 1'b0;
            s_d.ticks  = '0;
        end else if (s_q.active && tick) begin
            if (({1'b0, s_q.ticks} + 1'b1) >= {1'b0, period_i}) begin
                s_d.ticks  = '0;
                s_d.launch = 1'b1;
            end else begin
                s_d.ticks = s_q.ticks + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign launch_o = s_q.launch;

    // R4: a stop command leaves no launch behind it
    p_stop_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> !launch_o);

endmodule

// File: rtl/pfc_fetch.sv
module pfc_fetch
    import pfc_pkg::*;
#(
    parameter int unsigned MAX_LEN = 32,
    parameter int unsigned LEN_W   = $clog2(MAX_LEN + 1),
    parameter int unsigned IDX_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           launch_i,
    input  logic [BYTE_W-1:0]              win_off_i,
    input  logic [LEN_W-1:0]               win_len_i,
    input  logic [DEV_W-1:0]               dev_i,
    output logic                           bus_req_o,
    output logic [DEV_W-1:0]               bus_dev_o,
    output logic [BYTE_W-1:0]              bus_off_o,
    input  logic                           bus_done_i,
    input  logic                           bus_nack_i,
    input  logic [BYTE_W-1:0]              bus_rdata_i,
    output logic                           commit_o,
    output logic                           abort_o,
    output logic [MAX_LEN-1:0][BYTE_W-1:0] stage_o,
    output logic [BYTE_W-1:0]              snap_off_o,
    output logic [LEN_W-1:0]               snap_len_o
);
    typedef struct packed {
        fetch_state_e                  st;
        logic [IDX_W-1:0]              idx;
        logic [BYTE_W-1:0]             off;
        logic [LEN_W-1:0]              len;
        logic [DEV_W-1:0]              dev;
        logic [MAX_LEN-1:0][BYTE_W-1:0] stage;
        logic                          commit;
        logic                          abort;
    } fetch_t;

    fetch_t f_q, f_d;
    logic   last_byte;

    always_comb begin
        f_d        = f_q;
        f_d.commit = 1'b0;
        f_d.abort  = 1'b0;
        last_byte  = ((LEN_W'(f_q.idx) + 1'b1) == f_q.len);
        case (f_q.st)
            F_IDLE: begin
                if (launch_i) begin
                    f_d.st  = F_ISSUE;
                    f_d.idx = '0;
                    f_d.off = win_off_i;
                    f_d.len = win_len_i;
                    f_d.dev = dev_i;
                end
            end
            F_ISSUE: begin
                if (bus_done_i) begin
                    if (bus_nack_i) begin
                        f_d.st    = F_IDLE;
                        f_d.abort = 1'b1;
                    end else begin
                        f_d.stage[f_q.idx] = bus_rdata_i;
                        if (last_byte) begin
                            f_d.st     = F_IDLE;
                            f_d.commit = 1'b1;
                        end else begin
                            f_d.idx = f_q.idx + 1'b1;
                            f_d.st  = F_GAP;
                        end
                    end
                end
            end
            F_GAP:   f_d.st = F_ISSUE;
            default: f_d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            f_q     <= '0;
            f_q.st  <= F_IDLE;
            f_q.len <= LEN_W'(1);
        end else begin
            f_q <= f_d;
        end
    end

    assign bus_req_o  = (f_q.st == F_ISSUE);
    assign bus_dev_o  = f_q.dev;
    assign bus_off_o  = f_q.off + BYTE_W'(f_q.idx);
    assign commit_o   = f_q.commit;
    assign abort_o    = f_q.abort;
    assign stage_o    = f_q.stage;
    assign snap_off_o = f_q.off;
    assign snap_len_o = f_q.len;

    // R2: a pending request keeps its offset and device until done
    p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && !bus_done_i) |=> (bus_req_o && $stable(bus_off_o) && $stable(bus_dev_o)));

    // R7: a refused byte ends the fetch and signals the abort
    p_nack_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && bus_done_i && bus_nack_i) |=> (!bus_req_o && abort_o && !commit_o));

endmodule

// File: rtl/pfc_store.sv
module pfc_store
    import pfc_pkg::*;
#(
    parameter int unsigned MAX_LEN = 32,
    parameter int unsigned LEN_W   = $clog2(MAX_LEN + 1),
    parameter int unsigned IDX_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           commit_i,
    input  logic                           abort_i,
    input  logic                           release_i,
    input  logic [MAX_LEN-1:0][BYTE_W-1:0] stage_i,
    input  logic [BYTE_W-1:0]              snap_off_i,
    input  logic [LEN_W-1:0]               snap_len_i,
    input  logic                           host_rd_i,
    input  logic [BYTE_W-1:0]              host_addr_i,
    output logic                           gate_o,
    output logic                           hit_o,
    output logic [BYTE_W-1:0]              data_o
);
    typedef struct packed {
        logic                           gate;
        logic [BYTE_W-1:0]              off;
        logic [LEN_W-1:0]               len;
        logic [MAX_LEN-1:0][BYTE_W-1:0] mem;
    } store_t;

    store_t         s_q, s_d;
    logic [BYTE_W:0] diff;
    logic           in_win;

    always_comb begin
        s_d = s_q;
        if (commit_i) begin
            s_d.mem  = stage_i;
            s_d.off  = snap_off_i;
            s_d.len  = snap_len_i;
            s_d.gate = 1'b1;
        end
        if (abort_i)   s_d.gate = 1'b0;
        if (release_i) s_d.gate = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q     <= '0;
            s_q.len <= LEN_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        diff   = {1'b0, host_addr_i} - {1'b0, s_q.off};
        in_win = !diff[BYTE_W] && ({1'b0, diff[BYTE_W-1:0]} < (BYTE_W + 1)'(s_q.len));
        hit_o  = host_rd_i && s_q.gate && in_win;
        data_o = hit_o ? s_q.mem[diff[IDX_W-1:0]] : '0;
    end

    assign gate_o = s_q.gate;

    // R5: a completed fetch opens the gate unless released in the same cycle
    p_commit_serve_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_i && !release_i) |=> gate_o);

    // R7: an aborted fetch closes the gate
    p_abort_close_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_i |=> !gate_o);

    // R8: the served copy changes only on a commit
    p_served_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !commit_i |=> $stable(s_q.mem));

endmodule

// File: rtl/pfc_engine.sv
module pfc_engine
    import pfc_pkg::*;
#(
    parameter int unsigned CLKS_PER_TICK = 625000,
    parameter int unsigned MAX_LEN       = 32
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cfg_we_i,
    input  logic [2:0] cfg_addr_i,
    input  logic [7:0] cfg_wdata_i,
    output logic       cfg_err_o,
    output logic       gate_o,
    output logic       bus_req_o,
    output logic [6:0] bus_dev_o,
    output logic [7:0] bus_off_o,
    input  logic       bus_done_i,
    input  logic       bus_nack_i,
    input  logic [7:0] bus_rdata_i,
    input  logic       host_rd_i,
    input  logic [7:0] host_addr_i,
    output logic       host_hit_o,
    output logic [7:0] host_data_o
);
    localparam int unsigned LEN_W    = $clog2(MAX_LEN + 1);
    localparam int unsigned IDX_W    = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam int unsigned PERIOD_W = 8;
    localparam logic [7:0]  MAX_LEN_B = 8'(MAX_LEN);

    typedef struct packed {
        logic [PERIOD_W-1:0] period;
        logic [BYTE_W-1:0]   off;
        logic [LEN_W-1:0]    len;
        logic                tsel;
        logic [DEV_W-1:0]    dev0;
        logic [DEV_W-1:0]    dev1;
        logic                err;
    } cfg_t;

    cfg_t c_q, c_d;
    logic start_p, stop_p, release_p;
    logic launch;
    logic commit, abort;
    logic [MAX_LEN-1:0][BYTE_W-1:0] stage;
    logic [BYTE_W-1:0] snap_off;
    logic [LEN_W-1:0]  snap_len;
    logic [DEV_W-1:0]  sel_dev;
    logic              gate;
    logic              errclr_wr;

    always_comb begin
        c_d       = c_q;
        start_p   = 1'b0;
        stop_p    = 1'b0;
        release_p = 1'b0;
        if (cfg_we_i) begin
            case (cfg_reg_e'(cfg_addr_i))
                REG_PERIOD: c_d.period = cfg_wdata_i;
                REG_OFFSET: begin
                    if (gate) c_d.err = 1'b1;
                    else      c_d.off = cfg_wdata_i;
                end
                REG_LENGTH: begin
                    if (gate || (cfg_wdata_i == 8'd0) || (cfg_wdata_i > MAX_LEN_B)) c_d.err = 1'b1;
                    else c_d.len = LEN_W'(cfg_wdata_i);
                end
                REG_TSEL: begin
                    if (gate) c_d.err  = 1'b1;
                    else      c_d.tsel = cfg_wdata_i[0];
                end
                REG_DEV0: c_d.dev0 = cfg_wdata_i[7:1];
                REG_DEV1: c_d.dev1 = cfg_wdata_i[7:1];
                REG_CTRL: begin
                    start_p   = cfg_wdata_i[CTRL_START];
                    stop_p    = cfg_wdata_i[CTRL_STOP];
                    release_p = cfg_wdata_i[CTRL_RELEASE];
                    if (cfg_wdata_i[CTRL_ERRCLR]) c_d.err = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            c_q      <= '0;
            c_q.len  <= LEN_W'(1);
            c_q.dev0 <= 7'h50;
            c_q.dev1 <= 7'h51;
        end else begin
            c_q <= c_d;
        end
    end

    assign sel_dev = c_q.tsel ? c_q.dev1 : c_q.dev0;

    pfc_sched #(
        .CLKS_PER_TICK (CLKS_PER_TICK),
        .PERIOD_W      (PERIOD_W)
    ) sched_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_p),
        .stop_i   (stop_p),
        .period_i (c_q.period),
        .launch_o (launch)
    );

    pfc_fetch #(
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W),
        .IDX_W   (IDX_W)
    ) fetch_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .launch_i    (launch),
        .win_off_i   (c_q.off),
        .win_len_i   (c_q.len),
        .dev_i       (sel_dev),
        .bus_req_o   (bus_req_o),
        .bus_dev_o   (bus_dev_o),
        .bus_off_o   (bus_off_o),
        .bus_done_i  (bus_done_i),
        .bus_nack_i  (bus_nack_i),
        .bus_rdata_i (bus_rdata_i),
        .commit_o    (commit),
        .abort_o     (abort),
        .stage_o     (stage),
        .snap_off_o  (snap_off),
        .snap_len_o  (snap_len)
    );

    pfc_store #(
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W),
        .IDX_W   (IDX_W)
    ) store_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .commit_i    (commit),
        .abort_i     (abort),
        .release_i   (release_p),
        .stage_i     (stage),
        .snap_off_i  (snap_off),
        .snap_len_i  (snap_len),
        .host_rd_i   (host_rd_i),
        .host_addr_i (host_addr_i),
        .gate_o      (gate),
        .hit_o       (host_hit_o),
        .data_o      (host_data_o)
    );

    assign gate_o    = gate;
    assign cfg_err_o = c_q.err;
    assign errclr_wr = cfg_we_i && (cfg_addr_i == REG_CTRL) && cfg_wdata_i[CTRL_ERRCLR];

    // R10: the error flag holds until an explicit clear
    p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_err_o && !errclr_wr) |=> cfg_err_o);

    // R9: an offset write while serving leaves the offset and raises the error
    p_off_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate && cfg_we_i && (cfg_addr_i == REG_OFFSET)) |=> ($stable(c_q.off) && cfg_err_o));

endmodule

// File: tb/pfc_engine_tb_top.sv
`timescale 1ns/1ps
module pfc_engine_tb_top;

    localparam int unsigned TICK = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       cfg_err, gate;
    logic       bus_req;
    logic [6:0] bus_dev;
    logic [7:0] bus_off;
    logic       bus_done = 1'b0;
    logic       bus_nack = 1'b0;
    logic [7:0] bus_rdata = '0;
    logic       host_rd = 1'b0;
    logic [7:0] host_addr = '0;
    logic       host_hit;
    logic [7:0] host_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [7:0] salt = 8'h00;
    logic       nack_on = 1'b0;
    logic [7:0] nack_off = 8'h00;
    logic [7:0] watch_off = 8'h00;
    logic [7:0] log_off [0:63];
    logic [6:0] log_dev [0:63];
    int         log_n = 0;
    int         stamp [0:15];
    int         st_n = 0;

    always #4 clk = ~clk;

    pfc_engine #(.CLKS_PER_TICK(TICK), .MAX_LEN(32)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .cfg_err_o(cfg_err), .gate_o(gate),
        .bus_req_o(bus_req), .bus_dev_o(bus_dev), .bus_off_o(bus_off),
        .bus_done_i(bus_done), .bus_nack_i(bus_nack), .bus_rdata_i(bus_rdata),
        .host_rd_i(host_rd), .host_addr_i(host_addr),
        .host_hit_o(host_hit), .host_data_o(host_data)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] dmodel(input logic [6:0] d, input logic [7:0] o);
        return o ^ salt ^ {d, 1'b0};
    endfunction

    // downstream bus responder
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bus_req) begin
                if (log_n < 64) begin
                    log_off[log_n] = bus_off;
                    log_dev[log_n] = bus_dev;
                end
                log_n = log_n + 1;
                if (bus_off == watch_off && st_n < 16) begin
                    stamp[st_n] = cyc;
                    st_n = st_n + 1;
                end
                repeat (2) @(negedge clk);
                bus_rdata = dmodel(bus_dev, bus_off);
                bus_nack  = nack_on && (bus_off == nack_off);
                bus_done  = 1'b1;
                @(negedge clk);
                bus_done  = 1'b0;
                bus_nack  = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input string tag, input logic rd, input logic [7:0] a,
                         input logic eh, input logic [7:0] ed);
        @(negedge clk);
        host_rd = rd; host_addr = a;
        #1;
        chk({tag, " hit"}, host_hit, eh);
        chk({tag, " data"}, host_data, ed);
        host_rd = 1'b0;
    endtask

    task automatic clear_log(input logic [7:0] w);
        log_n = 0; st_n = 0; watch_off = w;
    endtask

    task automatic t_reset;
        chk("R1 gate", gate, 0);
        chk("R1 err", cfg_err, 0);
        chk("R1 req", bus_req, 0);
        probe("R1 read", 1'b1, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic t_basic;
        salt = 8'h3C;
        cfg_wr(3'd1, 8'h10);
        cfg_wr(3'd2, 8'd4);
        clear_log(8'h10);
        cfg_wr(3'd6, 8'h01);
        repeat (40) @(negedge clk);
        chk("R2 byte count", log_n, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R2 order", log_off[i], 8'h10 + 8'(i));
            chk("R11 default dev0", log_dev[i], 7'h50);
        end
        chk("R5 gate serving", gate, 1);
        for (int i = 0; i < 4; i++)
            probe("R5 in window", 1'b1, 8'h10 + 8'(i), 1'b1, dmodel(7'h50, 8'h10 + 8'(i)));
    endtask

    task automatic t_miss;
        probe("R6 below", 1'b1, 8'h0F, 1'b0, 8'h00);
        probe("R6 above", 1'b1, 8'h14, 1'b0, 8'h00);
        probe("R6 strobe low", 1'b0, 8'h10, 1'b0, 8'h00);
    endtask

    task automatic t_lock;
        cfg_wr(3'd1, 8'h40);
        chk("R9 err on locked write", cfg_err, 1);
        probe("R9 window kept", 1'b1, 8'h10, 1'b1, dmodel(7'h50, 8'h10));
        cfg_wr(3'd2, 8'd8);
        probe("R9 length kept", 1'b1, 8'h14, 1'b0, 8'h00);
        cfg_wr(3'd6, 8'h02);
        cfg_wr(3'd1, 8'h41);
        chk("R10 err still sticky", cfg_err, 1);
        cfg_wr(3'd6, 8'h04);
        chk("R9 release", gate, 0);
        probe("R6 gate closed", 1'b1, 8'h10, 1'b0, 8'h00);
        cfg_wr(3'd6, 8'h08);
        chk("R10 err clear", cfg_err, 0);
        cfg_wr(3'd1, 8'h40);
        chk("R9 unlocked write no err", cfg_err, 0);
    endtask

    task automatic t_dev1;
        cfg_wr(3'd3, 8'h01);
        cfg_wr(3'd5, 8'hB7);
        clear_log(8'h40);
        cfg_wr(3'd6, 8'h01);
        repeat (40) @(negedge clk);
        chk("R11 dev1 address", log_dev[0], 7'h5B);
        chk("R2 new offset", log_off[0], 8'h40);
        probe("R11 dev1 data", 1'b1, 8'h43, 1'b1, dmodel(7'h5B, 8'h43));
        cfg_wr(3'd6, 8'h04);
        cfg_wr(3'd3, 8'h00);
    endtask

    task automatic t_length;
        cfg_wr(3'd2, 8'd0);
        chk("R10 len zero rejected", cfg_err, 1);
        cfg_wr(3'd6, 8'h08);
        cfg_wr(3'd2, 8'd33);
        chk("R10 len 33 rejected", cfg_err, 1);
        cfg_wr(3'd6, 8'h08);
        cfg_wr(3'd2, 8'd32);
        cfg_wr(3'd1, 8'hE0);
        chk("R10 len 32 accepted", cfg_err, 0);
        salt = 8'h11;
        clear_log(8'hE0);
        cfg_wr(3'd6, 8'h01);
        repeat (200) @(negedge clk);
        chk("R2 full window count", log_n, 32);
        chk("R2 last offset", log_off[31], 8'hFF);
        probe("R5 first byte", 1'b1, 8'hE0, 1'b1, dmodel(7'h50, 8'hE0));
        probe("R5 last byte", 1'b1, 8'hFF, 1'b1, dmodel(7'h50, 8'hFF));
        probe("R6 just below", 1'b1, 8'hDF, 1'b0, 8'h00);
    endtask

    task automatic t_nack;
        nack_on = 1'b1; nack_off = 8'hE5;
        clear_log(8'hE0);
        cfg_wr(3'd6, 8'h01);
        repeat (60) @(negedge clk);
        chk("R7 requests stop", log_n, 6);
        chk("R7 gate auto clear", gate, 0);
        probe("R7 read misses", 1'b1, 8'hE0, 1'b0, 8'h00);
        nack_on = 1'b0;
    endtask

    task automatic t_stage;
        cfg_wr(3'd1, 8'h20);
        cfg_wr(3'd2, 8'd4);
        salt = 8'hA5;
        clear_log(8'h20);
        cfg_wr(3'd6, 8'h01);
        repeat (40) @(negedge clk);
        chk("R5 gate serving", gate, 1);
        salt = 8'h5A;
        clear_log(8'h20);
        cfg_wr(3'd6, 8'h01);
        while (log_n < 3) @(negedge clk);
        probe("R8 old byte0 mid-fetch", 1'b1, 8'h20, 1'b1, 8'h20 ^ 8'hA5 ^ 8'hA0);
        probe("R8 old byte1 mid-fetch", 1'b1, 8'h21, 1'b1, 8'h21 ^ 8'hA5 ^ 8'hA0);
        repeat (40) @(negedge clk);
        probe("R8 new byte0", 1'b1, 8'h20, 1'b1, dmodel(7'h50, 8'h20));
        probe("R8 new byte3", 1'b1, 8'h23, 1'b1, dmodel(7'h50, 8'h23));
    endtask

    task automatic t_period;
        cfg_wr(3'd0, 8'd3);
        clear_log(8'h20);
        cfg_wr(3'd6, 8'h01);
        repeat (200) @(negedge clk);
        chk("R3 fetch count", st_n, 4);
        chk("R3 spacing a", stamp[2] - stamp[1], 3 * TICK);
        chk("R3 spacing b", stamp[3] - stamp[2], 3 * TICK);
        cfg_wr(3'd6, 8'h02);
        repeat (30) @(negedge clk);
        clear_log(8'h20);
        repeat (200) @(negedge clk);
        chk("R4 no fetch after stop", st_n, 0);
        chk("R4 gate kept", gate, 1);
    endtask

    task automatic t_oneshot;
        cfg_wr(3'd0, 8'd0);
        clear_log(8'h20);
        cfg_wr(3'd6, 8'h01);
        repeat (200) @(negedge clk);
        chk("R3 single fetch", st_n, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL all: watchdog expired, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_miss();
        t_lock();
        t_dev1();
        t_length();
        t_nack();
        t_stage();
        t_period();
        t_oneshot();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule